// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is a synchronous I2C target that runs on a system clock much faster than the serial clock. It samples the bus lines through synchronizers and finds start, repeated start and stop conditions by comparing successive samples. After a start, it takes in an address byte. The block responds only when the seven address bits equal a fixed two-bit prefix followed by five bits taken from a configuration input.

A write transaction first loads an internal register pointer. Any further bytes in the same write go into a sixteen-entry, eight-bit register file, one entry after another. A read transaction returns register contents starting at the pointer left by an earlier write. The pointer moves forward after every byte transferred and wraps from the last entry to the first. The block only ever pulls the data line low, through an output enable, and releases it whenever it is not acknowledging or sending a zero bit.

Top module: `i2c_regptr_target`

## Requirements
- R1: Out of reset and whenever the bus is idle, `sda_oe_o` is 0.
- R2: The block acknowledges an address byte (drives SDA low in the ninth clock) only when address bits [7:1] equal {ADDR_HI, addr_lsb_i}, with ADDR_HI = 2'b01 by default. Bit 0 is the direction: 0 = write, 1 = read.
- R3: In a write, the first byte after the address sets the pointer from its low four bits. Each following byte is stored at the pointer, is acknowledged, and advances the pointer by one.
- R4: The block changes `sda_oe_o` only while the synchronized SCL is low.
- R5: In a read, the block sends the register at the pointer MSB first and advances the pointer by one for each byte sent. Reading N bytes from pointer p leaves the pointer at p+N.
- R6: The pointer wraps from 15 to 0, for both writes and reads.
- R7: When the master answers a read byte with a NACK (SDA high in the ninth clock), the block releases SDA and keeps it released until the next start or stop.
- R8: A repeated start during a transaction restarts address reception, so a write that sets the pointer can be followed by a read in the same bus tenure.
- R9: After a stop, or after an address that does not match, SDA stays released: no acknowledge is given to any later byte until the next start.
- R10: Bytes sent after a non-matching address leave the register file and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_lsb_i | input | 5 | Low five bits of the target address |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench uses the default parameters: sixteen registers, prefix 2'b01 and two synchronizer stages. The address input is set first to 5'b10110 and later to 5'b01001. With sixteen entries, a single write burst fills the whole file and a short burst crosses the wrap point, so every register and the 15-to-0 wrap can be checked by readback. The first address setting has a sweep over all 128 seven-bit addresses with the write direction, so exactly one value must be acknowledged. Then come NACK handling, a repeated start, writes sent to a foreign address, and the change of the configured address.

// File: rtl/i2c_regptr_pkg.sv
package i2c_regptr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } tgt_state_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_PTR,
        RX_DATA
    } rx_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] scl;
        logic [DEPTH-1:0] sda;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  scl_p, sda_p;

    always_comb begin
        pipe_d.scl = {pipe_q.scl[DEPTH-2:0], scl_i};
        pipe_d.sda = {pipe_q.sda[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    always_comb begin
        scl_s     = pipe_q.scl[DEPTH-2];
        sda_s     = pipe_q.sda[DEPTH-2];
        scl_p     = pipe_q.scl[DEPTH-1];
        sda_p     = pipe_q.sda[DEPTH-1];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int PW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_d [NREG];
    logic [DW-1:0] mem_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we && (waddr == PW'(g))) mem_d[g] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_regptr_pkg::*;
#(
    parameter int         PW      = 4,
    parameter logic [1:0] ADDR_HI = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [4:0]        addr_lsb,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PW-1:0]     ptr,
    output logic              sda_oe,
    output logic              is_idle,
    output logic              is_wait
);
    typedef struct packed {
        tgt_state_e        st;
        rx_kind_e          kind;
        logic [BYTE_W-1:0] sr;
        logic [3:0]        cnt;
        logic [PW-1:0]     ptr;
        logic              oe;
        logic              rd_mode;
        logic              mack_ok;
    } fsm_t;

    fsm_t s_d, s_q;
    logic addr_hit;

    assign addr_hit = (s_q.sr[7:1] == {ADDR_HI, addr_lsb});

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        if (stop_det) begin
            s_d.st = ST_IDLE;
            s_d.oe = 1'b0;
        end else if (start_det) begin
            s_d.st   = ST_RX;
            s_d.kind = RX_ADDR;
            s_d.cnt  = '0;
            s_d.oe   = 1'b0;
        end else begin
            case (s_q.st)
                ST_RX: begin
                    if (scl_rise && (s_q.cnt < 4'd8)) begin
                        s_d.sr  = {s_q.sr[BYTE_W-2:0], sda_s};
                        s_d.cnt = s_q.cnt + 4'd1;
                    end else if (scl_fall && (s_q.cnt == 4'd8)) begin
                        case (s_q.kind)
                            RX_ADDR: begin
                                if (addr_hit) begin
                                    s_d.st      = ST_ACK;
                                    s_d.oe      = 1'b1;
                                    s_d.rd_mode = s_q.sr[0];
                                end else begin
                                    s_d.st = ST_WAIT;
                                end
                            end
                            RX_PTR: begin
                                s_d.ptr = s_q.sr[PW-1:0];
                                s_d.st  = ST_ACK;
                                s_d.oe  = 1'b1;
                            end
                            default: begin
                                wr_en   = 1'b1;
                                s_d.ptr = s_q.ptr + 1'b1;
                                s_d.st  = ST_ACK;
                                s_d.oe  = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        s_d.cnt = '0;
                        if (s_q.rd_mode) begin
                            s_d.st  = ST_TX;
                            s_d.sr  = rd_data;
                            s_d.ptr = s_q.ptr + 1'b1;
                            s_d.oe  = ~rd_data[BYTE_W-1];
                        end else begin
                            s_d.st   = ST_RX;
                            s_d.kind = (s_q.kind == RX_ADDR) ? RX_PTR : RX_DATA;
                            s_d.oe   = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (s_q.cnt == 4'd7) begin
                            s_d.st = ST_MACK;
                            s_d.oe = 1'b0;
                        end else begin
                            s_d.sr  = {s_q.sr[BYTE_W-2:0], 1'b0};
                            s_d.cnt = s_q.cnt + 4'd1;
                            s_d.oe  = ~s_q.sr[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        s_d.mack_ok = ~sda_s;
                    end else if (scl_fall) begin
                        if (s_q.mack_ok) begin
                            s_d.st  = ST_TX;
                            s_d.cnt = '0;
                            s_d.sr  = rd_data;
                            s_d.ptr = s_q.ptr + 1'b1;
                            s_d.oe  = ~rd_data[BYTE_W-1];
                        end else begin
                            s_d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.kind <= RX_ADDR;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_data = s_q.sr;
    assign ptr     = s_q.ptr;
    assign sda_oe  = s_q.oe;
    assign is_idle = (s_q.st == ST_IDLE);
    assign is_wait = (s_q.st == ST_WAIT);
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
    import i2c_regptr_pkg::*;
#(
    parameter int         NREG        = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] ADDR_HI     = 2'b01,
    localparam int        PW          = $clog2(NREG)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] addr_lsb_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, fsm_idle, fsm_wait;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic [PW-1:0]     cur_ptr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_target_fsm #(.PW(PW), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_lsb  (addr_lsb_i),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ptr       (cur_ptr),
        .sda_oe    (sda_oe_o),
        .is_idle   (fsm_idle),
        .is_wait   (fsm_wait)
    );

    i2c_reg_array #(.NREG(NREG), .DW(BYTE_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (cur_ptr),
        .wdata (wr_data),
        .raddr (cur_ptr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/i2c_regptr_chk.sv
module i2c_regptr_chk #(
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_s,
    input logic          start_det,
    input logic          stop_det,
    input logic          we,
    input logic [PW-1:0] ptr,
    input logic          idle,
    input logic          waiting
);
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sda_oe);

    p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (ptr != '1)) |=> (ptr == PW'($past(ptr) + 1'b1)));

    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (ptr == '1)) |=> (ptr == '0));

    p_nack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !sda_oe);

    p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    p_wait_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !we);
endmodule

bind i2c_regptr_target i2c_regptr_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe_o),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .we        (wr_en),
    .ptr       (cur_ptr),
    .idle      (fsm_idle),
    .waiting   (fsm_wait)
);

// File: tb/i2c_regptr_target_test.sv
module i2c_regptr_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WDOG       = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] lsb = 5'b10110;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       oe;
    logic       sda_bus;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    logic [7:0] model [16];
    logic [3:0] mptr = 4'd0;

    assign sda_bus = m_sda & ~oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regptr_target uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_lsb_i (lsb),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input bit b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_bit(output bit b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    function automatic logic [6:0] own_addr();
        return {2'b01, lsb};
    endfunction

    task automatic set_ptr(input logic [3:0] p, input string req);
        bit a;
        bus_start();
        send_byte({own_addr(), 1'b0}, a);
        check(a, req, a, 1);
        send_byte({4'h0, p}, a);
        check(a, req, a, 1);
        mptr = p;
        bus_stop();
    endtask

    task automatic read_burst(input int n, input string req);
        bit a;
        logic [7:0] v;
        bus_start();
        send_byte({own_addr(), 1'b1}, a);
        check(a, req, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            check(v == model[mptr], req, v, model[mptr]);
            mptr = mptr + 4'd1;
        end
        bus_stop();
    endtask

    task automatic write_burst(input logic [3:0] p, input int n, input int seed, input string req);
        bit a;
        logic [7:0] v;
        bus_start();
        send_byte({own_addr(), 1'b0}, a);
        check(a, req, a, 1);
        send_byte({4'h0, p}, a);
        check(a, req, a, 1);
        mptr = p;
        for (int i = 0; i < n; i++) begin
            v = 8'((i * 37 + seed) & 255);
            send_byte(v, a);
            check(a, req, a, 1);
            model[mptr] = v;
            mptr = mptr + 4'd1;
        end
        bus_stop();
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit a;
        bit b;
        logic [7:0] v;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: released after reset and on an idle bus
        check(oe == 1'b0, "R1", oe, 0);

        // R2 / R9: sweep every 7-bit address with the write direction
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            send_byte({7'(ad), 1'b0}, a);
            check(a == (7'(ad) == own_addr()), "R2", a, (7'(ad) == own_addr()));
            bus_stop();
            check(oe == 1'b0, "R9", oe, 0);
        end

        // R9 / R10: bytes after a foreign address get no acknowledge and store nothing
        bus_start();
        send_byte({own_addr() ^ 7'h01, 1'b0}, a);
        check(!a, "R9", a, 0);
        send_byte(8'h00, a);
        check(!a, "R9", a, 0);
        send_byte(8'hA5, a);
        check(!a, "R10", a, 0);
        send_byte(8'h5A, a);
        check(!a, "R10", a, 0);
        bus_stop();
        set_ptr(4'd0, "R10");
        read_burst(2, "R10");

        // R3: fill the whole file in one burst
        write_burst(4'd0, 16, 5, "R3");
        // R5: read it all back
        set_ptr(4'd0, "R5");
        read_burst(16, "R5");
        check(mptr == 4'd0, "R5", mptr, 0);

        // R6: wrap on write and on read
        write_burst(4'd14, 3, 91, "R6");
        set_ptr(4'd14, "R6");
        read_burst(3, "R6");
        set_ptr(4'd15, "R6");
        read_burst(2, "R6");

        // R8: pointer write then repeated start into a read
        bus_start();
        send_byte({own_addr(), 1'b0}, a);
        check(a, "R8", a, 1);
        send_byte(8'h05, a);
        check(a, "R8", a, 1);
        mptr = 4'd5;
        bus_start();
        send_byte({own_addr(), 1'b1}, a);
        check(a, "R8", a, 1);
        recv_byte(1'b0, v);
        check(v == model[5], "R8", v, model[5]);
        mptr = 4'd6;
        bus_stop();

        // R7: after a NACK the line stays released
        bus_start();
        send_byte({own_addr(), 1'b1}, a);
        check(a, "R7", a, 1);
        recv_byte(1'b0, v);
        check(v == model[6], "R7", v, model[6]);
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            check(b == 1'b1, "R7", b, 1);
        end
        bus_stop();
        mptr = 4'd7;
        read_burst(1, "R7");

        // R2: a new configured address takes effect and the old one is ignored
        lsb = 5'b01001;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte({2'b01, 5'b10110, 1'b0}, a);
        check(!a, "R2", a, 0);
        bus_stop();
        set_ptr(4'd9, "R2");
        read_burst(1, "R2");
        check(oe == 1'b0, "R1", oe, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule